// File: doc/BRIEF.md
# Erased-Page-Transparent NAND Page Parity Generator

This block computes Reed-Solomon check symbols for one 512-byte NAND flash page as the page streams past on an 8-bit bus. Every accepted byte is forwarded unchanged and appears on a 10-bit output, zero-extended. Meanwhile the byte is turned into a 10-bit code symbol and fed to a systematic RS(518,512) encoder over GF(2^10). After the 512th byte, the block emits six 10-bit parity symbols, and the writer stores them in the spare area.

Before encoding, each byte is conditioned: its two upper symbol bits are forced to one and the whole symbol is inverted. The parity is also inverted on its way out. With both inversions, a fully erased page (every byte 0xFF) encodes to six words of 0x3FF. That is exactly what erased spare cells already read, so a blank page passes the parity check without any special-case logic.

A start-of-page pulse restarts the calculation at any point, including during the parity phase. Cycles without valid input are simply skipped.

Top module: `nand_page_parity`

## Requirements
- R1: While reset (synchronous, active high) is held and in the first cycle after it, out_valid, out_parity and out_sym are all zero and the symbol position is zero.
- R2: For the first 512 accepted symbols of a page, the next cycle shows out_valid=1, out_parity=0 and out_sym = {2'b00, byte}.
- R3: The next 6 accepted cycles after the data phase show out_parity=1 and a parity symbol. The in_byte value presented in those cycles has no effect on any output.
- R4: The encoder input symbol is the bitwise inverse of {2'b11, byte}. The field is built on x^10+x^3+1. A six-stage register runs as follows: the feedback is stage 0 XOR the input symbol; stage i (for i<5) takes stage i+1 XOR feedback*g_i; stage 5 takes feedback*g_5. The constants g_0..g_5 are 967, 305, 606, 312, 981 and 21. The parity is emitted stage 0 first and inverted, with zeros shifted into the top stage.
- R5: A page of 512 bytes of 0xFF yields six parity words of 0x3FF.
- R6: A cycle with in_valid=0 produces out_valid=0 in the following cycle and does not advance the symbol position.
- R7: After 518 accepted symbols the position wraps to zero, so the next byte starts a fresh page with a cleared register even when in_sop is not asserted.
- R8: in_sop clears the register and the position. If it comes together with in_valid, that byte is symbol 0 of a new page. This holds in any phase, including the parity phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte on in_byte is accepted this cycle |
| in_sop | input | 1 | Start of page: clear encoder state and position |
| in_byte | input | 8 | Flash data byte |
| out_valid | output | 1 | out_sym carries a symbol |
| out_parity | output | 1 | High while out_sym is a parity symbol |
| out_sym | output | 10 | Forwarded data byte (zero-extended) or inverted parity symbol |

## Verification
The case that needs care is a start-of-page pulse that lands in the same cycle as a parity shift or a data accumulation. The clear and the step must then merge: the accepted byte is encoded from a zeroed register at position zero. The bench provokes this by restarting a page three symbols into the parity phase, and again 100 bytes into a data phase, in each case with a valid byte in the pulse cycle. It judges the outcome against a software polynomial-division model that discards the aborted page. The restarted erased page must still produce six 0x3FF words, and a leftover parity word or a stale register shows up as an order or value mismatch.

// File: rtl/nrs_pkg.sv
package nrs_pkg;

    localparam int SYM_W     = 10;
    localparam int BYTE_W    = 8;
    localparam int PAR_SYMS  = 6;
    localparam logic [SYM_W-1:0] FIELD_LOW = 10'h009; // x^3 + 1 part of x^10+x^3+1

    typedef logic [SYM_W-1:0]  sym_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        PH_DATA   = 1'b0,
        PH_PARITY = 1'b1
    } phase_e;

    typedef struct packed {
        logic   valid;
        phase_e phase;
        sym_t   sym;
    } beat_t;

    // Generator polynomial lower coefficients, stage 0 upward.
    function automatic sym_t gen_coef(input int idx);
        sym_t c;
        case (idx)
            0:       c = 10'd967;
            1:       c = 10'd305;
            2:       c = 10'd606;
            3:       c = 10'd312;
            4:       c = 10'd981;
            default: c = 10'd21;
        endcase
        return c;
    endfunction

    // Field multiply, Horner form over the bits of b (MSB first).
    function automatic sym_t gf_mul(input sym_t a, input sym_t b);
        sym_t acc;
        acc = '0;
        for (int i = SYM_W - 1; i >= 0; i--) begin
            acc = acc[SYM_W-1] ? ({acc[SYM_W-2:0], 1'b0} ^ FIELD_LOW)
                               : {acc[SYM_W-2:0], 1'b0};
            if (b[i]) acc = acc ^ a;
        end
        return acc;
    endfunction

endpackage

// File: rtl/nrs_condition.sv
module nrs_condition
    import nrs_pkg::*;
(
    input  byte_t raw,
    output sym_t  enc_sym,
    output sym_t  pass_sym
);
    localparam int PAD_W = SYM_W - BYTE_W;

    sym_t widened;

    always_comb begin
        widened  = {{PAD_W{1'b1}}, raw};
        enc_sym  = ~widened;
        pass_sym = {{PAD_W{1'b0}}, raw};
    end
endmodule

// File: rtl/nrs_sequencer.sv
module nrs_sequencer
    import nrs_pkg::*;
#(
    parameter int DATA_SYMS = 512
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   take,
    input  logic   restart,
    output phase_e phase
);
    localparam int TOTAL = DATA_SYMS + PAR_SYMS;
    localparam int CNT_W = $clog2(TOTAL);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL - 1);
    localparam logic [CNT_W-1:0] DATA_END = CNT_W'(DATA_SYMS);

    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] pos_cur;

    always_comb begin
        pos_cur = restart ? '0 : pos_q;
        phase   = (pos_cur >= DATA_END) ? PH_PARITY : PH_DATA;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (take) begin
            pos_q <= (pos_cur == LAST) ? '0 : pos_cur + 1'b1;
        end else if (restart) begin
            pos_q <= '0;
        end
    end

    p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (take && !restart && pos_q == LAST) |=> (pos_q == '0));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!take && !restart) |=> $stable(pos_q));

    p_sop_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (restart && !take) |=> (pos_q == '0));

    p_range_r7: assert property (@(posedge clk) disable iff (rst)
        take |=> (pos_q <= LAST));
endmodule

// File: rtl/nrs_lfsr.sv
module nrs_lfsr
    import nrs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic accum,
    input  logic shift,
    input  sym_t sym_in,
    output sym_t head
);
    localparam int TOP = PAR_SYMS - 1;

    sym_t stage_q   [PAR_SYMS];
    sym_t stage_cur [PAR_SYMS];
    sym_t nxt_acc   [PAR_SYMS];
    sym_t nxt_shf   [PAR_SYMS];
    sym_t fb;

    always_comb begin
        for (int i = 0; i < PAR_SYMS; i++) begin
            stage_cur[i] = clear ? '0 : stage_q[i];
        end
        fb   = stage_cur[0] ^ sym_in;
        head = stage_cur[0];
    end

    for (genvar g = 0; g < PAR_SYMS; g++) begin : g_stage
        sym_t prod;
        assign prod = gf_mul(fb, gen_coef(g));
        if (g == TOP) begin : g_top
            assign nxt_acc[g] = prod;
            assign nxt_shf[g] = '0;
        end else begin : g_mid
            assign nxt_acc[g] = stage_cur[g+1] ^ prod;
            assign nxt_shf[g] = stage_cur[g+1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[g] <= '0;
            end else if (accum) begin
                stage_q[g] <= nxt_acc[g];
            end else if (shift) begin
                stage_q[g] <= nxt_shf[g];
            end else if (clear) begin
                stage_q[g] <= '0;
            end
        end
    end

    p_shift_fill_r3: assert property (@(posedge clk) disable iff (rst)
        shift |=> (stage_q[TOP] == '0));

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clear && !accum && !shift) |=> (stage_q[0] == '0 && stage_q[TOP] == '0));

    p_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
        !(accum && shift));
endmodule

// File: rtl/nand_page_parity.sv
module nand_page_parity
    import nrs_pkg::*;
#(
    parameter int DATA_SYMS = 512
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_sop,
    input  logic [7:0] in_byte,
    output logic       out_valid,
    output logic       out_parity,
    output logic [9:0] out_sym
);
    phase_e phase;
    sym_t   enc_sym;
    sym_t   pass_sym;
    sym_t   head;
    logic   do_accum;
    logic   do_shift;
    beat_t  beat_q;
    beat_t  beat_d;

    nrs_condition u_cond (
        .raw      (in_byte),
        .enc_sym  (enc_sym),
        .pass_sym (pass_sym)
    );

    nrs_sequencer #(.DATA_SYMS(DATA_SYMS)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .take    (in_valid),
        .restart (in_sop),
        .phase   (phase)
    );

    assign do_accum = in_valid && (phase == PH_DATA);
    assign do_shift = in_valid && (phase == PH_PARITY);

    nrs_lfsr u_lfsr (
        .clk    (clk),
        .rst    (rst),
        .clear  (in_sop),
        .accum  (do_accum),
        .shift  (do_shift),
        .sym_in (enc_sym),
        .head   (head)
    );

    always_comb begin
        beat_d.valid = in_valid;
        beat_d.phase = in_valid ? phase : PH_DATA;
        beat_d.sym   = !in_valid            ? '0 :
                       (phase == PH_PARITY) ? ~head : pass_sym;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_d;
        end
    end

    assign out_valid  = beat_q.valid;
    assign out_parity = (beat_q.phase == PH_PARITY);
    assign out_sym    = beat_q.sym;

    p_flag_valid_r3: assert property (@(posedge clk) disable iff (rst)
        out_parity |-> out_valid);

    p_zero_ext_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_parity) |-> (out_sym[9:8] == 2'b00));

    p_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_sop_data_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sop) |=> (out_valid && !out_parity));
endmodule

// File: tb/tb_nand_page_parity.sv
module tb_nand_page_parity;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_sop = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_valid;
    logic       out_parity;
    logic [9:0] out_sym;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    nand_page_parity dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
        .in_byte(in_byte), .out_valid(out_valid), .out_parity(out_parity),
        .out_sym(out_sym)
    );

    always #2 clk = ~clk;

    // Expected stream
    logic [9:0] q_sym[$];
    logic       q_par[$];
    string      q_tag[$];
    string      ctx = "";

    // Bench model state
    int         m_pos = 0;
    logic [7:0] m_msg [512];
    logic [9:0] m_par [6];

    function automatic logic [9:0] ref_mul(input logic [9:0] a, input logic [9:0] b);
        logic [9:0] p = '0;
        logic [9:0] aa = a;
        for (int i = 0; i < 10; i++) begin
            if (b[i]) p ^= aa;
            aa = aa[9] ? ({aa[8:0], 1'b0} ^ 10'h009) : {aa[8:0], 1'b0};
        end
        return p;
    endfunction

    task automatic compute_parity();
        logic [9:0] g [6];
        logic [9:0] r [6];
        logic [9:0] m;
        logic [9:0] fb;
        g[0] = 10'd967; g[1] = 10'd305; g[2] = 10'd606;
        g[3] = 10'd312; g[4] = 10'd981; g[5] = 10'd21;
        for (int k = 0; k < 6; k++) r[k] = '0;
        for (int j = 0; j < 512; j++) begin
            m  = ~{2'b11, m_msg[j]};
            fb = r[0] ^ m;
            for (int k = 0; k < 5; k++) r[k] = r[k+1] ^ ref_mul(fb, g[k]);
            r[5] = ref_mul(fb, g[5]);
        end
        for (int k = 0; k < 6; k++) m_par[k] = ~r[k];
    endtask

    function automatic bit msg_erased();
        for (int j = 0; j < 512; j++) if (m_msg[j] != 8'hFF) return 1'b0;
        return 1'b1;
    endfunction

    task automatic drive(input logic v, input logic s, input logic [7:0] b);
        @(negedge clk);
        in_valid = v;
        in_sop   = s;
        in_byte  = b;
        if (s) m_pos = 0;
        if (v) begin
            if (m_pos < 512) begin
                m_msg[m_pos] = b;
                q_sym.push_back({2'b00, b});
                q_par.push_back(1'b0);
                q_tag.push_back({"R2 ", ctx});
                if (m_pos == 511) compute_parity();
            end else begin
                q_sym.push_back(m_par[m_pos-512]);
                q_par.push_back(1'b1);
                q_tag.push_back(msg_erased() ? {"R5 ", ctx} : {"R4 R3 ", ctx});
            end
            m_pos = (m_pos == 517) ? 0 : m_pos + 1;
        end
    endtask

    function automatic logic [7:0] pat(input int kind, input int i);
        case (kind)
            0:       return 8'hFF;
            1:       return 8'h00;
            2:       return 8'(i * 37 + 5);
            default: return 8'(i) ^ 8'h5A;
        endcase
    endfunction

    // Parity-phase bytes are arbitrary garbage (R3: ignored)
    task automatic page(input int kind, input int gap_every, input int count, input bit sop_first);
        for (int i = 0; i < count; i++) begin
            drive(1'b1, (i == 0) && sop_first,
                  (i < 512) ? pat(kind, i) : 8'(i * 13 + 7));
            if (gap_every > 0 && (i % gap_every) == gap_every - 1)
                drive(1'b0, 1'b0, 8'(i));
        end
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (q_sym.size() == 0) begin
                    check(1'b0, "R6 unexpected output", {22'd0, out_sym}, 32'd0);
                end else begin
                    logic [9:0] es;
                    logic       ep;
                    string      et;
                    es = q_sym.pop_front();
                    ep = q_par.pop_front();
                    et = q_tag.pop_front();
                    check(out_parity == ep, {et, " parity flag"}, {31'd0, out_parity}, {31'd0, ep});
                    check(out_sym == es, {et, " symbol"}, {22'd0, out_sym}, {22'd0, es});
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired got %0d expected below 100000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0,  "R1 out_valid in reset",  {31'd0, out_valid}, 32'd0);
        check(out_parity == 1'b0, "R1 out_parity in reset", {31'd0, out_parity}, 32'd0);
        check(out_sym == 10'd0,   "R1 out_sym in reset",    {22'd0, out_sym}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", {31'd0, out_valid}, 32'd0);

        ctx = "erased page";          page(0, 0, 518, 1'b1);
        ctx = "zero page";            page(1, 0, 518, 1'b1);
        ctx = "R6 gapped page";       page(2, 7, 518, 1'b1);
        ctx = "R7 wrap without sop";  page(3, 0, 518, 1'b0);
        ctx = "R8 abort in data";     page(2, 0, 100, 1'b1);
        ctx = "R8 after data abort";  page(3, 0, 518, 1'b1);
        ctx = "R8 abort in parity";   page(1, 0, 515, 1'b1);
        ctx = "R8 sop during parity"; page(0, 0, 518, 1'b1);
        ctx = "R8 partial";           page(2, 0, 50, 1'b1);
        drive(1'b0, 1'b1, 8'h00);
        ctx = "R8 lone sop then page"; page(0, 3, 518, 1'b0);
        drive(1'b0, 1'b0, 8'h00);
        repeat (5) drive(1'b0, 1'b0, 8'hA5);
        check(q_sym.size() == 0, "R6 outstanding expected items", q_sym.size(), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule